// File: doc/BRIEF.md
# Packed Frame Handshake Transmitter

This block sends one message from the host to a radio peripheral over a parallel byte bus. The bus carries only 7 bits of data per byte. Payload bytes arrive on a valid/ready stream, and a last marker ends the message. The block holds the payload in a local buffer and computes a 16-bit CRC over it. When the message is complete, the block raises host-busy and waits a programmable setup delay. It then sends the frame one byte at a time. Each byte transfer is a four-phase strobe/acknowledge cycle.

The frame is sent in this order:
1. The transmit-request code.
2. A length byte.
3. The payload, followed by one CRC byte. Bit 7 is cleared in every one of these bytes.

The cleared top bits are not lost. They are gathered into a carrier byte, which is sent after every seventh data byte. A shorter carrier closes the frame when the total is not a multiple of seven.

If an acknowledge edge does not arrive within a fixed number of cycles, the block abandons the frame. A message longer than the buffer is drained from the stream and rejected, and nothing is sent on the bus. In every case the block ends with a one-cycle done pulse and a status code.

States:
- `ST_IDLE`: waiting for the first beat.
- `ST_LOAD`: accepting payload.
- `ST_DRAIN`: discarding an oversize message.
- `ST_SETUP`: host-busy is high and the setup delay runs.
- `ST_PICK`: selects the next byte.
- `ST_PLACE`: the byte sits on the bus with the strobe low.
- `ST_STROBE`: waits for the acknowledge to rise.
- `ST_RELEASE`: waits for the acknowledge to fall.
- `ST_FINISH`: the done pulse.

Transitions:
- Idle goes to load on any accepted beat.
- Load goes to setup on a beat that carries last.
- Idle or load goes to drain (or straight to finish, if that beat carries last) on a beat beyond the buffer size.
- Drain goes to finish on the beat that carries last.
- Setup goes to pick once the delay has elapsed.
- Pick goes to place, and place goes to strobe.
- Strobe goes to release when the acknowledge rises.
- Release goes to pick when the acknowledge falls. After the final carrier it goes to finish instead.
- Strobe or release goes to finish on a timeout.
- Finish goes to idle.

Top module: `pfh_tx`

## Requirements
- R1: Host-busy rises at least `setup_cycles`+1 cycles before the first strobe. The strobe is never high while host-busy is low. Host-busy falls only after the final acknowledge of the frame has gone low.
- R2: The first byte of every frame is 0x02.
- R3: The second byte is M + ceil(M/7), where M = N+1 and N is the number of payload bytes.
- R4: Each byte is placed before the strobe rises and stays stable while the strobe is high. The strobe rises only while the acknowledge is low, and it falls only after the acknowledge is high. The next strobe waits for the acknowledge to fall.
- R5: The data bytes go out in order, payload first and the CRC byte last, each with bit 7 cleared. No byte on the bus ever has bit 7 set.
- R6: The original bit 7 of the data byte at index i (counting from 0) is carried in bit 6-(i mod 7) of its group's carrier. Carrier bit 7 is 0.
- R7: A carrier follows every seventh data byte. A partial carrier follows the final data byte when M is not a multiple of 7. No empty carrier is ever sent.
- R8: The CRC byte is the low 8 bits of a reflected x^16+x^12+x^5+1 CRC that starts from zero. Each byte is processed low nibble first, then high nibble, using the step c = (c>>4) ^ (((c ^ nibble) & 0xF) * 0x1081).
- R9: If a wait for the acknowledge to rise, or to fall, lasts `TIMEOUT_CYCLES` cycles, the frame is aborted. Strobe and host-busy drop, and done is reported with status 1.
- R10: A message of up to `MAX_PAYLOAD` bytes is sent. A longer one is fully drained from the stream and reported with status 2, with no host-busy and no strobe.
- R11: After reset, busy, done, host-busy and strobe are low and `s_ready` is high. Every message ends with a single-cycle done pulse, with status 0 on success, and busy then returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_cycles | input | DLY_W | Delay from host-busy to the first byte; hold stable during a frame |
| s_valid | input | 1 | Payload beat valid |
| s_ready | output | 1 | Payload beat accepted |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Final beat of the message |
| bus_data | output | 8 | Parallel data bus |
| host_busy | output | 1 | Frame in progress toward the peripheral |
| strobe | output | 1 | Byte command strobe |
| ack | input | 1 | Peripheral acknowledge |
| busy | output | 1 | Block not idle |
| done | output | 1 | One-cycle end-of-message pulse |
| status | output | 2 | 0 ok, 1 handshake timeout, 2 message too long |

## Verification
The bench drives messages of varied lengths, with random delays on the acknowledge side, and rebuilds the expected bus byte stream on its own.

It aims at the following corner cases, each of which exposes a specific mistake:
- **Multiple of seven** (N=6 and N=13). A design that always closes with a carrier would append an empty one.
- **Top bits set** (all-0xFF and 0x80 payloads). A wrong shift in the carrier would scramble these bits.
- **Largest accepted length and one byte more.** A miscounted limit would either reject a legal message or put an oversize one on the bus.
- **Silent peripheral.** The bench holds the acknowledge low in one test and stuck high in another. A design with a missing or wrong timeout would hang or drop host-busy early.

// File: rtl/pfh_pkg.sv
package pfh_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LOAD, ST_DRAIN, ST_SETUP, ST_PICK,
        ST_PLACE, ST_STROBE, ST_RELEASE, ST_FINISH
    } pfh_state_e;

    typedef enum logic [1:0] {
        K_START, K_COUNT, K_DATA, K_CARRIER
    } pfh_kind_e;

    typedef enum logic [1:0] {
        STAT_OK = 2'd0, STAT_TIMEOUT = 2'd1, STAT_TOO_LONG = 2'd2
    } pfh_status_e;

    localparam logic [7:0] START_CODE = 8'h02;
    localparam int         GROUP      = 7;

    // One reflected 4-bit step of the x^16+x^12+x^5+1 CRC
    function automatic logic [15:0] crc_nibble(logic [15:0] c, logic [3:0] nib);
        logic [15:0] idx;
        idx = {12'd0, c[3:0] ^ nib};
        return (c >> 4) ^ (idx * 16'h1081);
    endfunction

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
        return crc_nibble(crc_nibble(c, b[3:0]), b[7:4]);
    endfunction

endpackage

// File: rtl/pfh_crc_acc.sv
module pfh_crc_acc
    import pfh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc_lo
);
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= 16'd0;
        else if (clear)
            crc_q <= en ? crc_byte(16'd0, din) : 16'd0;
        else if (en)
            crc_q <= crc_byte(crc_q, din);
    end

    assign crc_lo = crc_q[7:0];
endmodule

// File: rtl/pfh_frame_buf.sv
module pfh_frame_buf #(
    parameter int DEPTH = 110,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr < AW'(DEPTH)))
            mem[waddr] <= wdata;
    end

    assign rdata = (raddr < AW'(DEPTH)) ? mem[raddr] : 8'd0;
endmodule

// File: rtl/pfh_cycle_cnt.sv
module pfh_cycle_cnt #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            value <= '0;
        else if (value != '1)
            value <= value + 1'b1;
    end
endmodule

// File: rtl/pfh_tx.sv
module pfh_tx
    import pfh_pkg::*;
#(
    parameter int MAX_PAYLOAD    = 110,
    parameter int TIMEOUT_CYCLES = 4096,
    parameter int DLY_W          = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] setup_cycles,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic [7:0]       bus_data,
    output logic             host_busy,
    output logic             strobe,
    input  logic             ack,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status
);
    localparam int AW   = $clog2(MAX_PAYLOAD + 2);
    localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam int TW   = (DLY_W > TO_W) ? DLY_W : TO_W;
    localparam logic [AW-1:0] MAX_N   = AW'(MAX_PAYLOAD);
    localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYCLES - 1);

    pfh_state_e  state_q, state_d;
    pfh_kind_e   kind_q;
    pfh_status_e stat_q, stat_d;
    logic [AW-1:0] wcount_q, n_q, idx_q;
    logic [2:0]    grp_q;
    logic [6:0]    carrier_q;
    logic [7:0]    bus_q, rd_byte, crc_lo, cur_byte, count_byte;
    logic [AW:0]   m_total;
    logic [TW-1:0] tmr;
    logic          beat, loading, wr_en, overflow, tmr_clr, last_carrier;

    assign beat     = s_valid && s_ready;
    assign loading  = (state_q == ST_IDLE) || (state_q == ST_LOAD);
    assign wr_en    = beat && loading && (wcount_q < MAX_N);
    assign overflow = beat && loading && (wcount_q == MAX_N);
    assign m_total  = {1'b0, n_q} + 1'b1;
    assign count_byte   = 8'(m_total + (m_total + 6) / GROUP);
    assign cur_byte     = (idx_q == n_q) ? crc_lo : rd_byte;
    assign last_carrier = (kind_q == K_CARRIER) && (idx_q == n_q);
    assign tmr_clr      = (state_d != state_q);

    pfh_frame_buf #(.DEPTH(MAX_PAYLOAD), .AW(AW)) u_buf (
        .clk(clk), .we(wr_en), .waddr(wcount_q), .wdata(s_data),
        .raddr(idx_q), .rdata(rd_byte)
    );

    pfh_crc_acc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(state_q == ST_IDLE),
        .en(wr_en), .din(s_data), .crc_lo(crc_lo)
    );

    pfh_cycle_cnt #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clr), .value(tmr)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        stat_d  = stat_q;
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                if (overflow) begin
                    stat_d  = STAT_TOO_LONG;
                    state_d = s_last ? ST_FINISH : ST_DRAIN;
                end else if (beat) begin
                    state_d = s_last ? ST_SETUP : ST_LOAD;
                end
            end
            ST_DRAIN:   if (beat && s_last) state_d = ST_FINISH;
            ST_SETUP: begin
                stat_d = STAT_OK;
                if (tmr >= TW'(setup_cycles)) state_d = ST_PICK;
            end
            ST_PICK:    state_d = ST_PLACE;
            ST_PLACE:   state_d = ST_STROBE;
            ST_STROBE: begin
                if (ack) state_d = ST_RELEASE;
                else if (tmr == TO_LAST) begin
                    state_d = ST_FINISH;
                    stat_d  = STAT_TIMEOUT;
                end
            end
            ST_RELEASE: begin
                if (!ack) state_d = last_carrier ? ST_FINISH : ST_PICK;
                else if (tmr == TO_LAST) begin
                    state_d = ST_FINISH;
                    stat_d  = STAT_TIMEOUT;
                end
            end
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= STAT_OK;
            kind_q    <= K_START;
            wcount_q  <= '0;
            n_q       <= '0;
            idx_q     <= '0;
            grp_q     <= '0;
            carrier_q <= '0;
            bus_q     <= '0;
        end else begin
            stat_q <= stat_d;
            case (state_q)
                ST_IDLE, ST_LOAD: begin
                    if (wr_en) wcount_q <= wcount_q + 1'b1;
                    if (beat && s_last && !overflow) n_q <= wcount_q + 1'b1;
                end
                ST_SETUP: kind_q <= K_START;
                ST_PICK: begin
                    unique case (kind_q)
                        K_START:   bus_q <= START_CODE;
                        K_COUNT:   bus_q <= count_byte;
                        K_DATA: begin
                            bus_q     <= {1'b0, cur_byte[6:0]};
                            carrier_q <= ((grp_q == 3'd0) ? 7'd0 : carrier_q)
                                       | (cur_byte[7] ? (7'h40 >> grp_q) : 7'd0);
                        end
                        K_CARRIER: bus_q <= {1'b0, carrier_q};
                        default:   bus_q <= '0;
                    endcase
                end
                ST_RELEASE: begin
                    if (!ack) begin
                        unique case (kind_q)
                            K_START: kind_q <= K_COUNT;
                            K_COUNT: begin
                                kind_q <= K_DATA;
                                idx_q  <= '0;
                                grp_q  <= '0;
                            end
                            K_DATA: begin
                                if (grp_q == 3'(GROUP - 1) || idx_q == n_q)
                                    kind_q <= K_CARRIER;
                                else begin
                                    idx_q <= idx_q + 1'b1;
                                    grp_q <= grp_q + 1'b1;
                                end
                            end
                            K_CARRIER: begin
                                kind_q <= K_DATA;
                                idx_q  <= idx_q + 1'b1;
                                grp_q  <= '0;
                            end
                            default: kind_q <= K_START;
                        endcase
                    end
                end
                ST_FINISH: wcount_q <= '0;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        s_ready   = (state_q == ST_IDLE) || (state_q == ST_LOAD) || (state_q == ST_DRAIN);
        host_busy = (state_q == ST_SETUP) || (state_q == ST_PICK) || (state_q == ST_PLACE)
                 || (state_q == ST_STROBE) || (state_q == ST_RELEASE);
        strobe    = (state_q == ST_STROBE);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        status    = stat_q;
        bus_data  = bus_q;
    end

    a_r1_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> host_busy);
    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (!strobe || $stable(bus_data)));
    a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strobe) && host_busy) |-> $past(ack));
    a_r5_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !bus_data[7]);
    a_r10_no_accept_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> !s_ready);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_pfh_tx.sv
module tb_pfh_tx;
    localparam int TO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [19:0] setup_cycles = '0;
    logic       s_valid = 1'b0, s_last = 1'b0, ack;
    logic [7:0] s_data = '0;
    logic       s_ready, host_busy, strobe, busy, done;
    logic [7:0] bus_data;
    logic [1:0] status;

    pfh_tx #(.MAX_PAYLOAD(110), .TIMEOUT_CYCLES(TO), .DLY_W(20)) dut (
        .clk(clk), .rst_n(rst_n), .setup_cycles(setup_cycles),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .bus_data(bus_data), .host_busy(host_busy), .strobe(strobe), .ack(ack),
        .busy(busy), .done(done), .status(status)
    );

    int errors = 0, checks = 0;
    logic [7:0] pl [0:127];
    logic [7:0] exp_b [0:255];
    bit         exp_carr [0:255];
    int exp_n, crc_pos;
    logic [7:0] rx [0:255];
    int rx_n, pre_cnt, viol1, viol4, rel_bad, resp_mode;
    bit strobe_seen, hb_seen, done_seen, prev_hb, prev_st;
    logic [1:0] done_stat;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_crc(int n);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            c = (c >> 4) ^ (((c ^ int'(pl[i])) & 15) * 4225);
            c = (c >> 4) ^ (((c ^ (int'(pl[i]) >> 4)) & 15) * 4225);
            c = c & 16'hFFFF;
        end
        return c & 8'hFF;
    endfunction

    function automatic void build_expected(int n);
        int m = n + 1;
        int k = 2;
        int carr = 0;
        int b;
        exp_b[0] = 8'h02; exp_carr[0] = 0;
        exp_b[1] = 8'(m + (m + 6) / 7); exp_carr[1] = 0;
        for (int i = 0; i < m; i++) begin
            b = (i < n) ? int'(pl[i]) : ref_crc(n);
            if (i == n) crc_pos = k;
            exp_b[k] = 8'(b & 8'h7F); exp_carr[k] = 0; k++;
            if ((b & 8'h80) != 0) carr = carr | (8'h40 >> (i % 7));
            if ((i % 7) == 6 || i == m - 1) begin
                exp_b[k] = 8'(carr); exp_carr[k] = 1; k++;
                carr = 0;
            end
        end
        exp_n = k;
    endfunction

    // Peripheral model and monitors
    initial begin
        int dly = 0;
        ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (strobe && !host_busy) viol1++;
                if (host_busy) hb_seen = 1;
                if (host_busy && !strobe_seen) begin
                    if (strobe) strobe_seen = 1; else pre_cnt++;
                end
                if (prev_hb && !host_busy && ack && resp_mode == 0) rel_bad++;
                if (strobe && !prev_st && ack) viol4++;
                if (!strobe && prev_st && !ack && host_busy) viol4++;
                prev_hb = host_busy;
                prev_st = strobe;
                if (done) begin done_seen = 1; done_stat = status; end
                if (resp_mode != 1) begin
                    if (strobe && !ack) begin
                        if (dly > 0) dly--;
                        else begin
                            if (rx_n < 256) begin rx[rx_n] = bus_data; rx_n++; end
                            ack = 1'b1; dly = int'($urandom % 4);
                        end
                    end else if (!strobe && ack && resp_mode == 0) begin
                        if (dly > 0) dly--;
                        else begin ack = 1'b0; dly = int'($urandom % 4); end
                    end
                end
            end
        end
    end

    task automatic send(int n, int setup);
        int w = 0;
        setup_cycles = 20'(setup);
        rx_n = 0; pre_cnt = 0; strobe_seen = 0; hb_seen = 0;
        viol1 = 0; viol4 = 0; rel_bad = 0; done_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = pl[i]; s_last = (i == n - 1);
            while (!s_ready) @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        while (!done_seen && w < 20000) begin @(negedge clk); w++; end
        chk(done_seen, "R11", "done pulse", int'(done_seen), 1);
        @(negedge clk);
    endtask

    task automatic check_frame(int n, int setup);
        int dm = 0, cm = 0;
        build_expected(n);
        chk(done_stat == 2'd0, "R11", "status ok", int'(done_stat), 0);
        chk(!busy && !host_busy && !strobe, "R11", "idle after frame", int'(busy), 0);
        chk(rx_n == exp_n, "R7", "bytes on bus", rx_n, exp_n);
        chk(rx[0] == 8'h02, "R2", "start code", int'(rx[0]), 2);
        chk(rx[1] == exp_b[1], "R3", "length byte", int'(rx[1]), int'(exp_b[1]));
        for (int k = 2; k < exp_n && k < rx_n; k++) begin
            if (rx[k] != exp_b[k]) begin
                if (exp_carr[k]) cm++; else dm++;
            end
        end
        chk(dm == 0, "R5", "data byte mismatches", dm, 0);
        chk(cm == 0, "R6", "carrier mismatches", cm, 0);
        chk(crc_pos < rx_n && rx[crc_pos] == exp_b[crc_pos], "R8", "crc byte",
            int'(rx[crc_pos]), int'(exp_b[crc_pos]));
        chk(pre_cnt >= setup + 1, "R1", "setup cycles before strobe", pre_cnt, setup + 1);
        chk(viol1 == 0 && rel_bad == 0, "R1", "host-busy framing faults", viol1 + rel_bad, 0);
        chk(viol4 == 0, "R4", "handshake order faults", viol4, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed));
        resp_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !host_busy && !strobe && s_ready, "R11", "reset state",
            int'({busy, done, host_busy, strobe, s_ready}), 1);

        // R8 R6: single byte with top bit
        pl[0] = 8'h80; send(1, 0); check_frame(1, 0);
        // R7: M a multiple of seven, all top bits set
        for (int i = 0; i < 6; i++) pl[i] = 8'hFF;
        send(6, 3); check_frame(6, 3);
        for (int i = 0; i < 7; i++) pl[i] = 8'(8'h81 + i * 17);
        send(7, 1); check_frame(7, 1);
        for (int i = 0; i < 13; i++) pl[i] = 8'($urandom);
        send(13, 5); check_frame(13, 5);
        // R10: largest accepted length
        for (int i = 0; i < 110; i++) pl[i] = 8'($urandom);
        send(110, 2); check_frame(110, 2);
        // R10: one byte too many
        for (int i = 0; i < 111; i++) pl[i] = 8'($urandom);
        send(111, 2);
        chk(done_stat == 2'd2, "R10", "too-long status", int'(done_stat), 2);
        chk(rx_n == 0 && !hb_seen, "R10", "no bus activity", rx_n, 0);
        // R9: acknowledge never rises
        resp_mode = 1;
        for (int i = 0; i < 3; i++) pl[i] = 8'(i + 5);
        send(3, 0);
        chk(done_stat == 2'd1, "R9", "timeout on rise", int'(done_stat), 1);
        chk(!host_busy && !strobe, "R9", "lines released", int'(host_busy), 0);
        // R9: acknowledge stuck high
        resp_mode = 2;
        send(3, 0);
        chk(done_stat == 2'd1, "R9", "timeout on fall", int'(done_stat), 1);
        chk(!host_busy && !strobe && rx_n == 1, "R9", "aborted after first byte", rx_n, 1);
        resp_mode = 0;
        repeat (4) @(negedge clk);
        // random frames
        for (int f = 0; f < 12; f++) begin
            n = 1 + int'($urandom % 40);
            for (int i = 0; i < n; i++) pl[i] = 8'($urandom);
            send(n, int'($urandom % 16));
            check_frame(n, int'(setup_cycles));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule